// File: doc/BRIEF.md
# Sixteen-Channel Hertz-Programmed PWM Bank

The block drives a bank of independent pulse-width-modulated outputs from one fixed system clock. Each channel is set up by two 16-bit registers. One holds the repetition rate in hertz. The other holds the high time as a fraction of the period, where 0 means never high and 65535 means always high. Software writes these registers through a plain write port and can read any of them back through a separate read address.

Each channel tracks its period with a phase accumulator. The accumulator advances by the programmed rate on every clock and wraps at the clock rate. The output is high while the accumulated phase, scaled to 16 bits, stays below the duty value. New settings go first into a holding register. A channel copies them into its working set only when its current period ends, so a write never cuts a pulse short and never stretches one.

Top module: `pwm_bank`

## Requirements
- R1: Register word address 2n holds the duty of channel n and address 2n+1 holds its rate in hertz. Bit 0 of the address selects rate (1) or duty (0), and the upper bits select the channel.
- R2: `rd_data` combinationally shows the register selected by `rd_addr`. A write is visible there from the cycle after the clock edge that captured it.
- R3: After reset, every rate register reads 400, every duty register reads 0, and all outputs are low.
- R4: When the rate f divides `CLK_HZ`, one period lasts exactly `CLK_HZ`/f clock cycles. For any other f, periods average `CLK_HZ`/f cycles.
- R5: Within a period of P cycles, the output is high for the first ceil(duty·P/65535) cycles and low for the rest.
- R6: A working duty of 0 keeps the output low for the whole period.
- R7: A working duty of 65535 with a nonzero rate keeps the output high for the whole period.
- R8: A working rate of 0 holds the output low. In that state the channel picks up its holding registers on every clock.
- R9: Writes take effect only at the next period start. The output rises only on the first cycle of a period.
- R10: Each channel runs from its own registers and is unaffected by writes to other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at `CLK_HZ` |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (5) | Word address of the write |
| wr_data | input | 16 | Value to write |
| rd_addr | input | AW (5) | Word address to read |
| rd_data | output | 16 | Content of the addressed register |
| pwm_o | output | NUM_CH (16) | One PWM output per channel |

## Verification
The bench builds the bank with `CLK_HZ` = 40000 and the default 16 channels. At that clock rate the reset rate of 400 Hz gives a period of 100 cycles, and rates of 1000, 2000 and 8000 Hz give periods of 40, 20 and 5 cycles. Full periods, period-boundary reloads, one-cycle pulses and mid-period rewrites therefore all fit in a few thousand clocks. Each of these rates divides the clock rate, so a reference model that counts cycles and uses integer arithmetic predicts every output bit exactly. The model also covers a zero rate and the two extreme duty values.

// File: rtl/pwm_pkg.sv
// Package: shared types and reset constants for the PWM bank.
// Assumes 16-bit rate and duty registers.
package pwm_pkg;
    localparam int REG_W = 16;
    localparam int DUTY_FULL = 65535;

    typedef struct packed {
        logic [REG_W-1:0] freq;
        logic [REG_W-1:0] duty;
    } chan_cfg_t;

    localparam chan_cfg_t RST_CFG = '{freq: 16'd400, duty: 16'd0};
endpackage

// File: rtl/pwm_regfile.sv
// Module: holding registers for all channels, with a write port and a
// combinational read port. Address bit 0 picks rate (1) or duty (0);
// the upper bits pick the channel. Out-of-range channels are ignored.
module pwm_regfile
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int AW = $clog2(2 * NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output chan_cfg_t         cfg_o [NUM_CH]
);
    localparam int CW = AW - 1;

    chan_cfg_t regs_q [NUM_CH];

    logic [CW-1:0] wr_ch;
    logic [CW-1:0] rd_ch;
    assign wr_ch = wr_addr[AW-1:1];
    assign rd_ch = rd_addr[AW-1:1];

    // Capture writes into the addressed field; reset loads 400 Hz and duty 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) regs_q[i] <= RST_CFG;
        end else if (wr_en && (int'(wr_ch) < NUM_CH)) begin
            if (wr_addr[0]) regs_q[wr_ch].freq <= wr_data;
            else            regs_q[wr_ch].duty <= wr_data;
        end
    end

    // Read mux: select the field named by rd_addr, zero outside the map.
    always_comb begin
        rd_data = '0;
        if (int'(rd_ch) < NUM_CH)
            rd_data = rd_addr[0] ? regs_q[rd_ch].freq : regs_q[rd_ch].duty;
    end

    assign cfg_o = regs_q;
endmodule

// File: rtl/pwm_channel.sv
// Module: one PWM channel built on a phase accumulator.
// The accumulator adds the working rate on every clock and wraps at
// CLK_HZ, which marks a period start. The output is high while
// phase*65535 < duty*CLK_HZ. Holding settings are copied into the working
// set only at a wrap, or on every clock while the working rate is 0.
// Assumes CLK_HZ > 65535 is not required; any positive CLK_HZ works.
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    localparam int PH_W  = $clog2(CLK_HZ + 65536),
    localparam int CMP_W = PH_W + REG_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  chan_cfg_t  cfg_i,
    output logic       pwm_o,
    output logic       start_o,
    output chan_cfg_t  act_o
);
    logic [PH_W-1:0] acc_q;
    chan_cfg_t       act_q;
    logic [PH_W:0]   sum;
    logic [PH_W:0]   rem;
    logic            idle;
    logic [CMP_W-1:0] phase_scaled;
    logic [CMP_W-1:0] duty_scaled;

    assign idle    = (act_q.freq == '0);
    assign sum     = {1'b0, acc_q} + (PH_W+1)'(act_q.freq);
    assign rem     = sum - (PH_W+1)'(CLK_HZ);
    assign start_o = idle || (sum >= (PH_W+1)'(CLK_HZ));

    // Advance the phase; at a wrap or while idle, load new settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            act_q <= RST_CFG;
        end else if (start_o) begin
            acc_q <= idle ? '0 : rem[PH_W-1:0];
            act_q <= cfg_i;
        end else begin
            acc_q <= sum[PH_W-1:0];
        end
    end

    // Duty decode: compare scaled phase against the scaled duty threshold.
    always_comb begin
        phase_scaled = CMP_W'(acc_q) * CMP_W'(DUTY_FULL);
        duty_scaled  = CMP_W'(act_q.duty) * CMP_W'(CLK_HZ);
        pwm_o        = !idle && (phase_scaled < duty_scaled);
    end

    assign act_o = act_q;
endmodule

// File: rtl/pwm_bank.sv
// Module: top of the PWM bank. One register file feeds NUM_CH generated
// channels. Working settings and period-start flags are gathered into flat
// vectors, which the bound checker observes.
module pwm_bank
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CLK_HZ = 50_000_000,
    localparam int AW = $clog2(2 * NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic [NUM_CH-1:0] pwm_o
);
    chan_cfg_t                 hold_cfg [NUM_CH];
    chan_cfg_t                 work_cfg [NUM_CH];
    logic [NUM_CH-1:0]         period_start;
    logic [NUM_CH*REG_W-1:0]   act_freq_flat;
    logic [NUM_CH*REG_W-1:0]   act_duty_flat;

    pwm_regfile #(.NUM_CH(NUM_CH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg_o   (hold_cfg)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        pwm_channel #(.CLK_HZ(CLK_HZ)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_i   (hold_cfg[n]),
            .pwm_o   (pwm_o[n]),
            .start_o (period_start[n]),
            .act_o   (work_cfg[n])
        );
        assign act_freq_flat[n*REG_W +: REG_W] = work_cfg[n].freq;
        assign act_duty_flat[n*REG_W +: REG_W] = work_cfg[n].duty;
    end
endmodule

// File: rtl/pwm_bank_chk.sv
// Checker: temporal properties of the PWM bank, bound to pwm_bank.
module pwm_bank_chk #(
    parameter int NUM_CH = 16,
    parameter int AW = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [AW-1:0]        wr_addr,
    input logic [15:0]          wr_data,
    input logic [AW-1:0]        rd_addr,
    input logic [15:0]          rd_data,
    input logic [NUM_CH-1:0]    pwm_o,
    input logic [NUM_CH-1:0]    period_start,
    input logic [NUM_CH*16-1:0] act_freq_flat,
    input logic [NUM_CH*16-1:0] act_duty_flat
);
    // R2
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_addr == wr_addr) |=> ($stable(rd_addr) -> rd_data == $past(wr_data)));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_p
        // R9
        hold_between_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !period_start[n] |=> ($stable(act_freq_flat[n*16 +: 16]) && $stable(act_duty_flat[n*16 +: 16])));
        // R9
        rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwm_o[n]) |-> $past(period_start[n]));
        // R6
        duty_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act_duty_flat[n*16 +: 16] == 16'd0) |-> !pwm_o[n]);
        // R7
        duty_full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act_duty_flat[n*16 +: 16] == 16'hFFFF && act_freq_flat[n*16 +: 16] != 16'd0) |-> pwm_o[n]);
        // R8
        freq_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act_freq_flat[n*16 +: 16] == 16'd0) |-> !pwm_o[n]);
    end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .pwm_o         (pwm_o),
    .period_start  (period_start),
    .act_freq_flat (act_freq_flat),
    .act_duty_flat (act_duty_flat)
);

// File: tb/tb_pwm_bank.sv
// Bench: cycle-counting reference model compared against the bank every clock.
module tb_pwm_bank;
    localparam int CLK_PERIOD = 10;
    localparam int MCLK = 40000;
    localparam int NCH = 16;
    localparam int AW = 5;

    logic clk = 0;
    logic rst_n = 0;
    logic wr_en = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic [NCH-1:0] pwm_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;
    bit live = 0;

    // Model state: cycle-in-period, working and holding settings.
    int mc [NCH];
    int maf [NCH];
    int mad [NCH];
    int mrf [NCH];
    int mrd [NCH];

    pwm_bank #(.NUM_CH(NCH), .CLK_HZ(MCLK)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit exp_pwm(int ch);
        longint p;
        if (maf[ch] == 0) return 1'b0;
        p = MCLK / maf[ch];
        return (longint'(mc[ch]) * 65535) < (longint'(mad[ch]) * p);
    endfunction

    function automatic int exp_rd(int a);
        return (a % 2) ? mrf[a/2] : mrd[a/2];
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Model update at each rising edge (same ordering as the requirements).
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                mc[i] = 0; maf[i] = 400; mad[i] = 0; mrf[i] = 400; mrd[i] = 0;
            end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (maf[i] == 0) begin
                    mc[i] = 0; maf[i] = mrf[i]; mad[i] = mrd[i];
                end else if (mc[i] == MCLK / maf[i] - 1) begin
                    mc[i] = 0; maf[i] = mrf[i]; mad[i] = mrd[i];
                end else begin
                    mc[i] = mc[i] + 1;
                end
            end
            if (wr_en) begin
                if (wr_addr[0]) mrf[wr_addr[4:1]] = int'(wr_data);
                else            mrd[wr_addr[4:1]] = int'(wr_data);
            end
        end
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // Every-cycle comparison of all outputs and the read port.
    always @(negedge clk) begin
        if (live) begin
            for (int i = 0; i < NCH; i++) begin
                string req;
                if (maf[i] == 0)          req = "R8";
                else if (mad[i] == 0)     req = "R6";
                else if (mad[i] == 65535) req = "R7";
                else                      req = "R5 R10";
                check(pwm_o[i] == exp_pwm(i), req, int'(pwm_o[i]), int'(exp_pwm(i)));
            end
            check(int'(rd_data) == exp_rd(int'(rd_addr)), "R2", int'(rd_data), exp_rd(int'(rd_addr)));
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk); #1;
        wr_en = 1; wr_addr = AW'(a); wr_data = 16'(d);
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #1;
            rd_addr = AW'(k % 32);
        end
    endtask

    initial begin
        int t0;
        repeat (4) @(negedge clk);
        #1 rst_n = 1;
        live = 1;
        // R3: reset contents and quiet outputs
        for (int a = 0; a < 32; a++) begin
            @(negedge clk); #1 rd_addr = AW'(a);
            #2 check(int'(rd_data) == ((a % 2) ? 400 : 0), "R3", int'(rd_data), (a % 2) ? 400 : 0);
        end
        check(pwm_o == '0, "R3", int'(pwm_o), 0);

        // R1: map checks through read-back of duty (2n) and rate (2n+1)
        wr(0, 32768);               // ch0 duty, rate stays 400 -> P=100
        wr(3, 2000); wr(2, 65535);  // ch1 P=20, always high
        wr(5, 0);    wr(4, 1000);   // ch2 rate 0 -> low
        wr(7, 8000); wr(6, 1);      // ch3 P=5, one-cycle pulse
        wr(9, 1000); wr(8, 20000);  // ch4 P=40
        wr(11, 8000); wr(10, 65535);// ch5 full
        @(negedge clk); #1 rd_addr = 5'd10;
        #2 check(rd_data == 16'hFFFF, "R1", int'(rd_data), 65535);
        rd_addr = 5'd11;
        #1 check(rd_data == 16'd8000, "R1", int'(rd_data), 8000);
        run(300);

        // R4: measured period of ch3 is 5 cycles
        @(negedge clk); while (!pwm_o[3]) @(negedge clk);
        t0 = cyc;
        @(negedge clk); while (!pwm_o[3]) @(negedge clk);
        check(cyc - t0 == 5, "R4", cyc - t0, 5);

        // R9: rewrite ch4 duty while high; pulse must finish unchanged
        @(negedge clk); while (!pwm_o[4]) @(negedge clk);
        #1 wr_en = 1; wr_addr = 5'd8; wr_data = 16'd0;
        @(negedge clk);
        check(pwm_o[4] == 1'b1, "R9", int'(pwm_o[4]), 1);
        #1 wr_en = 0;
        @(negedge clk);
        check(pwm_o[4] == 1'b1, "R9", int'(pwm_o[4]), 1);
        run(100);
        check(pwm_o[4] == 1'b0, "R9", int'(pwm_o[4]), 0);

        // R10: change ch0 rate mid-period, clear ch1, wake ch2
        wr(1, 1000);
        wr(2, 0);
        wr(5, 2000);
        run(400);
        wr(1, 0);
        run(200);
        live = 0;
        finish_run();
    end
endmodule